// File: doc/BRIEF.md
# Idle Condition Persistence Detector

The block follows a receive-side Idle indication over frames and turns it into a stable Idle state. A strobe marks the end of each frame. A companion flag on the strobe says whether the idle pattern was seen in that frame. The Idle state changes only after a long unbroken run of frames that point the other way. Each time the state changes, in either direction, the block can raise an interrupt.

Software reaches the block through a byte-wide register port. The port carries:
- the current Idle state as a read-only bit;
- an interrupt enable bit;
- a sticky interrupt status bit that is cleared when its register is read.

An active-low request line is asserted while an enabled status bit is set.

Top module: `idle_persist_det`

## Requirements
- R1: Idle goes to 1 on the clock edge that takes the 63rd consecutive strobe whose flag is 1 while Idle is 0. It shows as bit 5 of address 0x10, and all other bits of 0x10 read 0.
- R2: Idle goes to 0 on the clock edge that takes the 63rd consecutive strobe whose flag is 0 while Idle is 1.
- R3: A strobe whose flag equals the current Idle state restarts the run count from zero. Cycles without a strobe neither advance nor restart the count.
- R4: Bit 4 of address 0x12 is the interrupt enable. Writing it with 1 enables the interrupt and writing it with 0 disables it. It reads back at bit 4, and the other bits of 0x12 read 0.
- R5: Every change of Idle in either direction that occurs while the enable is 1 sets bit 4 of address 0x13. That bit stays set until it is cleared.
- R6: A change of Idle that occurs while the enable is 0 updates the Idle bit but leaves the status bit unchanged.
- R7: A read of 0x13 (read strobe high with address 0x13) returns the status as it was before the read, then clears the status at that clock edge. If a change of state occurs in the same cycle as the read, the status stays set.
- R8: irq_no is 0 exactly when the status bit and the enable bit are both 1, and is 1 otherwise.
- R9: Reset clears the Idle state, the run count, the enable and the status, and irq_no is 1 during reset. Addresses other than 0x10, 0x12 and 0x13 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe, one per received frame |
| frame_idle_i | input | 1 | Idle pattern seen in this frame, valid with the strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; clears the status register on read |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
Two functions can land on the same clock edge: the read of the status register that clears it, and a change of Idle that sets it. The bench lines up 62 frames of one kind and then puts the 63rd strobe in the same cycle as a read of 0x13. It expects the status to stay set and the request line to stay low. A behavioural model runs alongside the block every cycle, over both directed runs and long random runs that include read strobes and enable writes near state changes. It checks read data and the request line on every clock.

// File: rtl/idle_persist_pkg.sv
package idle_persist_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 8'h12;
  localparam logic [ADDR_W-1:0] ADDR_ISTS = 8'h13;
  localparam int unsigned IDLE_BIT = 5;
  localparam int unsigned IEN_BIT  = 4;
  localparam int unsigned ISTS_BIT = 4;
endpackage

// File: rtl/idle_persist_filter.sv
module idle_persist_filter #(
  parameter int unsigned THRESH = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic idle_i,
  output logic idle_o,
  output logic change_o
);
  localparam int unsigned CNT_W = $clog2(THRESH) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             idle_q;
  logic             differ;

  assign differ   = stb_i && (idle_i != idle_q);
  assign change_o = differ && (cnt_q == LAST);
  assign idle_o   = idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else if (stb_i) begin
      if (change_o) begin
        idle_q <= ~idle_q;
        cnt_q  <= '0;
      end else if (differ) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(THRESH));

  // R1 R2
  flip_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q != $past(idle_q)) |-> $past(stb_i && (idle_i != idle_q)));

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && (idle_i == idle_q)) |=> (cnt_q == '0));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(cnt_q) && $stable(idle_q));
endmodule

// File: rtl/idle_persist_regs.sv
module idle_persist_regs
  import idle_persist_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              change_i,
  input  logic              idle_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no
);
  logic ien_q;
  logic sts_q;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[DATA_W-1:IEN_BIT+1], wdata_i[IEN_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= 1'b0;
    end else if (wr_i && addr_i == ADDR_IEN) begin
      ien_q <= wdata_i[IEN_BIT];
    end
  end

  // a change of state beats a read-clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
    end else if (change_i && ien_q) begin
      sts_q <= 1'b1;
    end else if (rd_i && addr_i == ADDR_ISTS) begin
      sts_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_STAT: rdata_o[IDLE_BIT] = idle_i;
      ADDR_IEN:  rdata_o[IEN_BIT]  = ien_q;
      ADDR_ISTS: rdata_o[ISTS_BIT] = sts_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_no = ~(ien_q & sts_q);

  // R5
  sts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change_i && ien_q) |=> sts_q);

  // R6
  sts_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_q && !(change_i && ien_q)) |=> !sts_q);

  // R7
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_ISTS && !change_i) |=> !sts_q);

  // R4
  ien_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_IEN) |=> (ien_q == $past(wdata_i[IEN_BIT])));
endmodule

// File: rtl/idle_persist_det.sv
module idle_persist_det
  import idle_persist_pkg::*;
#(
  parameter int unsigned THRESH = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_stb_i,
  input  logic              frame_idle_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_no
);
  logic idle;
  logic change;

  idle_persist_filter #(.THRESH(THRESH)) filter_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (frame_stb_i),
    .idle_i   (frame_idle_i),
    .idle_o   (idle),
    .change_o (change)
  );

  idle_persist_regs regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .change_i (change),
    .idle_i   (idle),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .irq_no   (irq_no)
  );
endmodule

// File: tb/idle_persist_det_tb.sv
module idle_persist_det_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TH = 63;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, fi = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = 8'h10, wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_n;

  int total = 0, bad = 0;
  bit done = 0;

  bit m_idle = 0, m_ien = 0, m_sts = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_persist_det #(.THRESH(TH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_stb_i(stb), .frame_idle_i(fi),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_no(irq_n)
  );

  // behavioural reference
  always @(posedge clk) begin
    bit chg;
    bit old_ien;
    chg = 0;
    if (!rst_n) begin
      m_idle = 0; m_ien = 0; m_sts = 0; m_cnt = 0;
    end else begin
      if (stb) begin
        if (fi != m_idle) begin
          m_cnt++;
          if (m_cnt == TH) begin m_idle = ~m_idle; m_cnt = 0; chg = 1; end
        end else m_cnt = 0;
      end
      old_ien = m_ien;
      if (wr && addr == 8'h12) m_ien = wdata[4];
      if (rd && addr == 8'h13) m_sts = 0;
      if (chg && old_ien) m_sts = 1;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h10: return {2'b0, m_idle, 5'b0};
      8'h12: return {3'b0, m_ien, 4'b0};
      8'h13: return {3'b0, m_sts, 4'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h10: return "R1/R2 idle bit";
      8'h12: return "R4 enable";
      8'h13: return "R5 status";
      default: return "R9 unmapped";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    check(tag_of(addr), rdata, exp_rd(addr));
    check("R8 irq_no", {7'b0, irq_n}, {7'b0, ~(m_sts & m_ien)});
  endtask

  task automatic cyc(input bit s, input bit f, input bit w, input bit r,
                     input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    if (rst_n) cmp_all();
    stb = s; fi = f; wr = w; rd = r; addr = a; wdata = d;
  endtask

  task automatic frame(input bit v);
    cyc(1, v, 0, 0, 8'h10, 8'h00);
    cyc(0, 0, 0, 0, 8'h10, 8'h00);
  endtask

  task automatic peek(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    if (rst_n) cmp_all();
    stb = 0; wr = 0; rd = 0; addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    addr = 8'h10; #1; check("R9 reset idle", rdata, 8'h00);
    addr = 8'h12; #1; check("R9 reset enable", rdata, 8'h00);
    addr = 8'h13; #1; check("R9 reset status", rdata, 8'h00);
    check("R9 reset irq_no", {7'b0, irq_n}, 8'h01);
    @(negedge clk); rst_n = 1; addr = 8'h10;

    // R4 enable write, other bits read 0
    cyc(0, 0, 1, 0, 8'h12, 8'hFF);
    peek("R4 enable readback", 8'h12, 8'h10);

    // R1 + R3: 62 idle frames, break, then 63 more
    for (int i = 0; i < TH - 1; i++) frame(1);
    peek("R1 not yet after 62", 8'h10, 8'h00);
    frame(0);
    for (int i = 0; i < TH - 1; i++) frame(1);
    peek("R3 restart held idle low", 8'h10, 8'h00);
    repeat (20) cyc(0, 0, 0, 0, 8'h10, 8'h00);
    peek("R3 no strobe no change", 8'h10, 8'h00);
    frame(1);
    peek("R1 idle declared", 8'h10, 8'h20);
    peek("R5 status on declare", 8'h13, 8'h10);
    check("R8 irq low", {7'b0, irq_n}, 8'h00);

    // R7 read clears
    cyc(0, 0, 0, 1, 8'h13, 8'h00);
    peek("R7 status cleared", 8'h13, 8'h00);
    check("R8 irq high after clear", {7'b0, irq_n}, 8'h01);

    // R2 clear after 63 non-idle
    for (int i = 0; i < TH; i++) frame(0);
    peek("R2 idle cleared", 8'h10, 8'h00);
    peek("R5 status on clear", 8'h13, 8'h10);
    cyc(0, 0, 0, 1, 8'h13, 8'h00);

    // R6 disabled change
    cyc(0, 0, 1, 0, 8'h12, 8'h00);
    for (int i = 0; i < TH; i++) frame(1);
    peek("R6 idle updated", 8'h10, 8'h20);
    peek("R6 no status", 8'h13, 8'h00);
    check("R6 irq high", {7'b0, irq_n}, 8'h01);

    // R7 collision: change and read-clear on the same edge
    cyc(0, 0, 1, 0, 8'h12, 8'h10);
    for (int i = 0; i < TH - 1; i++) frame(0);
    cyc(1, 0, 0, 1, 8'h13, 8'h00);
    peek("R7 collision status kept", 8'h13, 8'h10);
    check("R7 collision irq low", {7'b0, irq_n}, 8'h00);
    peek("R2 idle cleared on collision", 8'h10, 8'h00);
    cyc(0, 0, 0, 1, 8'h13, 8'h00);

    // R9 unmapped
    peek("R9 addr 0x11", 8'h11, 8'h00);
    peek("R9 addr 0x00", 8'h00, 8'h00);
    peek("R9 addr 0xFF", 8'hFF, 8'h00);

    // random runs compared every cycle
    begin
      bit v = 0;
      for (int i = 0; i < 6000; i++) begin
        int r = $urandom_range(0, 199);
        if (r < 2) v = ~v;
        if (r == 10)      cyc(0, 0, 1, 0, 8'h12, {3'b0, 1'($urandom_range(0, 1)), 4'h0});
        else if (r < 16)  cyc($urandom_range(0, 1), v, 0, 1, 8'h13, 8'h00);
        else if (r < 20)  cyc(0, 0, 0, 0, 8'h12, 8'h00);
        else              cyc($urandom_range(0, 2) != 0, (r == 150) ? ~v : v, 0, 0, 8'h10, 8'h00);
      end
    end
    cyc(0, 0, 0, 0, 8'h10, 8'h00);

    done = 1;
    summary();
    $finish;
  end
endmodule